// File: doc/BRIEF.md
# Serial EEPROM Write Guard and Status Unit

This unit holds the status byte and the write-enable latch of a 512-byte serial memory. It decides whether a byte write or a status write requested by the serial engine may proceed. The serial engine supplies single-cycle strobes for the enable and disable commands. On every deselect it raises a chip-select-rise strobe along with the command type, the number of serial clocks counted during the selection, the address, and the byte shifted in.

A committed write starts a self-timed busy period. Its length is set by a parameter counted in system clocks. The status byte can be read on every cycle. While a status write is still busy, the status byte keeps showing the old protect bits.

A separate permit output tells the serial engine whether a byte write to the address now presented would be accepted.

Top module: `eeprom_wp_status`

## Requirements
- R1: `status_o` is {4'b1111, BP1, BP0, WEL, WIP} with BP1 at bit 3 and WIP at bit 0; after reset it reads 0xF0 and `busy_o` is 0.
- R2: A `wren_i` pulse while not busy and with `wp_n_i` high sets WEL, and WEL is set by nothing else.
- R3: WEL is cleared by a `wrdi_i` pulse, by `wp_n_i` low in any cycle (which takes priority over `wren_i`), and by any chip-select rise that closes a status-write or byte-write command, whether or not it commits; a chip-select rise with no such command leaves WEL unchanged.
- R4: A status write commits only on `cs_rise_i` with `op_wrsr_i`, `bit_cnt_i` exactly 16, WEL set, `wp_n_i` high and not busy; the new BP1,BP0 come from `sr_data_i[3:2]`.
- R5: A byte write commits only on `cs_rise_i` with `op_write_i`, `bit_cnt_i` at least 24 and a multiple of 8, WEL set, `wp_n_i` high, not busy, and the address unprotected; otherwise it starts no busy period.
- R6: Protected range by BP1,BP0: 00 none, 01 addresses 0x180-0x1FF, 10 addresses 0x100-0x1FF, 11 the whole array.
- R7: After a commit, WIP and `busy_o` are 1 for exactly TWR_CYCLES cycles, starting with the cycle after the commit edge.
- R8: During a status-write busy period, BP1,BP0 keep their old value; the new value appears in the same cycle that WIP returns to 0.
- R9: While busy, enable, disable and command strobes are ignored, and `wp_n_i` low cannot shorten the busy period.
- R10: `permit_o` is 1 exactly when WEL is set, `wp_n_i` is high, the unit is not busy, and `addr_i` is outside the protected range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| wp_n_i | input | 1 | Hardware write protect, low blocks writes |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| cs_rise_i | input | 1 | Chip-select rising edge strobe |
| op_wrsr_i | input | 1 | Current command is a status write |
| op_write_i | input | 1 | Current command is a byte write |
| bit_cnt_i | input | CNT_W | Serial clocks counted in this selection |
| sr_data_i | input | 8 | Status byte shifted in |
| addr_i | input | ADDR_W | Target byte address |
| status_o | output | 8 | Status byte |
| permit_o | output | 1 | Byte write at addr_i would be accepted |
| busy_o | output | 1 | Self-timed write in progress |

## Verification
Several rules are checked by assertions on every cycle. Only the enable strobe can raise WEL. A low protect pin empties the latch by the next cycle. WEL stays clear while busy. Every busy period begins with WEL set and the pin high. A status commit always follows a count of exactly 16. The protect bits stay frozen across a busy period.

Other behaviours can only be shown by the bench's scenarios. These are the rejection of 15 or 17 clocks and of unaligned write lengths, the address boundaries of each protect setting, the exact busy length, and the moment the new protect bits become visible.

// File: rtl/eeprom_wp_status.sv
module eeprom_wp_status #(
  parameter int ADDR_W     = 9,
  parameter int CNT_W      = 8,
  parameter int TWR_CYCLES = 5000,
  localparam int TMR_W     = $clog2(TWR_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              cs_rise_i,
  input  logic              op_wrsr_i,
  input  logic              op_write_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic [7:0]        sr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              permit_o,
  output logic              busy_o
);

  logic             wel_q;
  logic [1:0]       bp_q, bp_new_q;
  logic             bp_pend_q;
  logic [TMR_W-1:0] tmr_q;

  function automatic logic in_guard(input logic [1:0] bp, input logic [ADDR_W-1:0] a);
    case (bp)
      2'b01:   return &a[ADDR_W-1 -: 2];
      2'b10:   return a[ADDR_W-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  assign busy_o = (tmr_q != '0);

  wire guarded   = in_guard(bp_q, addr_i);
  wire len16     = (bit_cnt_i == CNT_W'(16));
  wire len_bytes = (bit_cnt_i >= CNT_W'(24)) && (bit_cnt_i[2:0] == 3'b000);
  wire cmd_close = cs_rise_i && !busy_o && (op_wrsr_i || op_write_i);
  wire may_write = wel_q && wp_n_i && !busy_o;
  wire sr_go     = cs_rise_i && op_wrsr_i && may_write && len16;
  wire wr_go     = cs_rise_i && op_write_i && !op_wrsr_i && may_write && len_bytes && !guarded;

  assign permit_o = may_write && !guarded;
  assign status_o = {4'b1111, bp_q, wel_q, busy_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   wel_q <= 1'b0;
    else if (!wp_n_i)                             wel_q <= 1'b0;
    else if (!busy_o && (wrdi_i || cmd_close))    wel_q <= 1'b0;
    else if (!busy_o && wren_i)                   wel_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tmr_q <= '0;
    else if (sr_go || wr_go)   tmr_q <= TMR_W'(TWR_CYCLES);
    else if (busy_o)           tmr_q <= tmr_q - TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q      <= 2'b00;
      bp_new_q  <= 2'b00;
      bp_pend_q <= 1'b0;
    end else if (sr_go) begin
      bp_new_q  <= sr_data_i[3:2];
      bp_pend_q <= 1'b1;
    end else if (bp_pend_q && tmr_q == TMR_W'(1)) begin
      bp_q      <= bp_new_q;
      bp_pend_q <= 1'b0;
    end
  end

  AST_WEL_ONLY_FROM_WREN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(wren_i)); // R2

  AST_WEL_CLEARED_BY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n_i |=> !status_o[1]); // R3

  AST_SR_COMMIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && $past(op_wrsr_i)) |-> ($past(bit_cnt_i) == CNT_W'(16))); // R4

  AST_COMMIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(status_o[1]) && $past(wp_n_i))); // R5

  AST_WRITE_NOT_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && $past(op_write_i) && !$past(op_wrsr_i)) |-> $past(permit_o)); // R6

  AST_BP_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(status_o[3:2])); // R8

  AST_WEL_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !status_o[1]); // R9

endmodule

// File: tb/eeprom_wp_status_tb.sv
module eeprom_wp_status_tb;
  localparam int TWR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1, wren = 1'b0, wrdi = 1'b0, csr = 1'b0, wrsr = 1'b0, wr = 1'b0;
  logic [7:0] cnt = '0, data = '0;
  logic [8:0] addr = '0;
  logic [7:0] status;
  logic permit, busy;
  int n_vec = 0, n_bad = 0, ticks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eeprom_wp_status #(.ADDR_W(9), .CNT_W(8), .TWR_CYCLES(TWR)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .wren_i(wren), .wrdi_i(wrdi),
    .cs_rise_i(csr), .op_wrsr_i(wrsr), .op_write_i(wr), .bit_cnt_i(cnt),
    .sr_data_i(data), .addr_i(addr), .status_o(status), .permit_o(permit),
    .busy_o(busy));

  // {wren,wrdi,wp_n,csr,wrsr,wr, cnt[8], data[8], addr[9], exp_status[8], exp_permit}
  localparam int NV = 19;
  localparam logic [39:0] VEC [NV] = '{
    {6'b001000, 8'd0,  8'h00, 9'h000, 8'hF0, 1'b0}, // R1 idle after reset
    {6'b101000, 8'd0,  8'h00, 9'h000, 8'hF2, 1'b1}, // R2 enable
    {6'b001000, 8'd0,  8'h00, 9'h1FF, 8'hF2, 1'b1}, // R6 none guarded
    {6'b011000, 8'd0,  8'h00, 9'h1FF, 8'hF0, 1'b0}, // R3 disable
    {6'b101000, 8'd0,  8'h00, 9'h000, 8'hF2, 1'b1},
    {6'b001100, 8'd8,  8'h00, 9'h000, 8'hF2, 1'b1}, // R3 plain deselect
    {6'b000000, 8'd0,  8'h00, 9'h000, 8'hF0, 1'b0}, // R3 pin low
    {6'b100000, 8'd0,  8'h00, 9'h000, 8'hF0, 1'b0}, // R3 pin beats enable
    {6'b101000, 8'd0,  8'h00, 9'h000, 8'hF2, 1'b1},
    {6'b001110, 8'd17, 8'h0C, 9'h000, 8'hF0, 1'b0}, // R4 17 clocks
    {6'b101000, 8'd0,  8'h00, 9'h000, 8'hF2, 1'b1},
    {6'b001110, 8'd15, 8'h0C, 9'h000, 8'hF0, 1'b0}, // R4 early rise
    {6'b101000, 8'd0,  8'h00, 9'h000, 8'hF2, 1'b1},
    {6'b001101, 8'd20, 8'h00, 9'h000, 8'hF0, 1'b0}, // R5 too short
    {6'b101000, 8'd0,  8'h00, 9'h000, 8'hF2, 1'b1},
    {6'b001101, 8'd25, 8'h00, 9'h000, 8'hF0, 1'b0}, // R5 unaligned
    {6'b101000, 8'd0,  8'h00, 9'h000, 8'hF2, 1'b1},
    {6'b000110, 8'd16, 8'h0C, 9'h000, 8'hF0, 1'b0}, // R4 pin low
    {6'b001101, 8'd24, 8'h00, 9'h000, 8'hF0, 1'b0}  // R5 latch clear
  };

  task automatic chk(input string tag, input logic [7:0] est, input logic ep);
    n_vec++;
    if (status !== est || permit !== ep || busy !== est[0]) begin
      n_bad++;
      $display("FAIL %s: status=%h permit=%b busy=%b expected status=%h permit=%b busy=%b",
               tag, status, permit, busy, est, ep, est[0]);
    end
  endtask

  task automatic step(input logic [5:0] ctl, input logic [7:0] c, input logic [7:0] d,
                      input logic [8:0] a, input logic [7:0] est, input logic ep, input string tag);
    {wren, wrdi, wp_n, csr, wrsr, wr} = ctl;
    cnt = c; data = d; addr = a;
    @(negedge clk);
    chk(tag, est, ep);
  endtask

  task automatic wait_busy(input logic [7:0] est_busy, input logic [7:0] est_end, input string tag);
    for (int k = 1; k < TWR; k++) step(6'b001000, 8'd0, 8'h00, addr, est_busy, 1'b0, tag);
    step(6'b001000, 8'd0, 8'h00, addr, est_end, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 5000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 8'hF0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++)
      step(VEC[i][39:34], VEC[i][33:26], VEC[i][25:18], VEC[i][17:9], VEC[i][8:1], VEC[i][0],
           $sformatf("R1-table row %0d", i));

    // R4 R7 R8 status write of BP=10, old bits visible while busy
    step(6'b101000, 8'd0, 8'h00, 9'h000, 8'hF2, 1'b1, "R2 enable");
    step(6'b001110, 8'd16, 8'h08, 9'h000, 8'hF1, 1'b0, "R4 commit");
    step(6'b101000, 8'd0, 8'h00, 9'h000, 8'hF1, 1'b0, "R9 enable while busy");
    step(6'b000000, 8'd0, 8'h00, 9'h000, 8'hF1, 1'b0, "R9 pin low while busy");
    step(6'b001000, 8'd0, 8'h00, 9'h000, 8'hF1, 1'b0, "R7 still busy");
    step(6'b001000, 8'd0, 8'h00, 9'h000, 8'hF8, 1'b0, "R8 new bits at end");

    // R6 R10 half guarded, R5 drop
    step(6'b101000, 8'd0, 8'h00, 9'h0FF, 8'hFA, 1'b1, "R10 below half");
    step(6'b001000, 8'd0, 8'h00, 9'h100, 8'hFA, 1'b0, "R6 half boundary");
    step(6'b001101, 8'd24, 8'h00, 9'h100, 8'hF8, 1'b0, "R5 guarded drop");

    // R5 R7 accepted byte write
    step(6'b101000, 8'd0, 8'h00, 9'h0FF, 8'hFA, 1'b1, "R2 enable");
    step(6'b001101, 8'd32, 8'h00, 9'h0FF, 8'hF9, 1'b0, "R5 commit");
    wait_busy(8'hF9, 8'hF8, "R7 write period");

    // quarter setting
    step(6'b101000, 8'd0, 8'h00, 9'h000, 8'hFA, 1'b1, "R2 enable");
    step(6'b001110, 8'd16, 8'h04, 9'h000, 8'hF9, 1'b0, "R4 commit quarter");
    wait_busy(8'hF9, 8'hF4, "R8 quarter");
    step(6'b101000, 8'd0, 8'h00, 9'h17F, 8'hF6, 1'b1, "R6 below quarter");
    step(6'b001000, 8'd0, 8'h00, 9'h180, 8'hF6, 1'b0, "R6 quarter boundary");

    // whole array
    step(6'b001110, 8'd16, 8'h0C, 9'h000, 8'hF5, 1'b0, "R4 commit whole");
    wait_busy(8'hF5, 8'hFC, "R8 whole");
    step(6'b101000, 8'd0, 8'h00, 9'h000, 8'hFE, 1'b0, "R6 whole guarded");
    step(6'b001101, 8'd24, 8'h00, 9'h000, 8'hFC, 1'b0, "R5 whole drop");

    // R1 reset returns status
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset again", 8'hF0, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule